// File: doc/BRIEF.md
# SYSREF Burst Pulser with Divider Phase Alignment

The block runs from one fast distribution clock. It produces a set of divided output clocks and one SYSREF line for JESD204B subclass 1 links. Every output divider divides the distribution clock by its own programmable integer. A separate SYSREF divider sets the SYSREF period. For example, from a 3000 MHz clock a value of 2 gives 1500 MHz, 20 gives 150 MHz and 300 gives 10 MHz.

A single SYNC path serves two roles. The internal SYNC level is the external pin XOR a polarity control, so writing the control high and then low acts as a software SYNC. In alignment mode, a SYNC rising edge restarts every divider whose hold bit is clear, all on the same cycle. In burst mode, the same edge arms a pulser, which then emits a counted train of SYSREF pulses. An output selector chooses what drives the SYSREF line: the synchronized SYNC level, the pulser, or nothing. A local clear input forces the SYSREF line low.

A typical bring-up runs in this order:
1. Align the dividers in alignment mode.
2. Set all hold bits.
3. Switch to burst mode with the pulser selected.

Top module: `sysref_sync_ctl`

## Requirements
- R1: While `rst_n` is low, `sysref_out` is 0 and every output whose divide value is 2 or more is 0. After reset, all divider counters start at count 0.
- R2: For a divide value N of 2 or more, `clk_out[i]` is periodic with N cycles. It is high for floor(N/2) cycles of each period, starting at count 0. Divide value i sits in bits `div_val[i*DW +: DW]`.
- R3: A divide value of 0 or 1 bypasses the divider: `clk_out[i]` follows `clk`.
- R4: The internal SYNC level is `sync_pin ^ sync_inv`. It passes through a two-flop synchronizer. With `sref_sel` = 0 and the clear low, `sysref_out` equals the internal SYNC level from two clock edges earlier.
- R5: When `sync_mode` = 1, a rising edge of the synchronized SYNC restarts every divider whose hold bit is 0 at count 0 (output high). All restarted dividers do this on the same edge, which is the third clock edge after the pin changes.
- R6: A divider whose bit in `div_hold` is 1 (or the SYSREF divider when `sref_hold` is 1) ignores SYNC and keeps counting.
- R7: When `sync_mode` = 2, a rising edge of the synchronized SYNC arms the pulser. The burst starts at the next SYSREF divider wrap to count 0. It lasts `burst_len`+1 SYSREF periods. Each pulse is high for floor(M/2) cycles, where M is `sref_div` and M ≥ 2. Afterwards the line stays low.
- R8: A SYNC edge that arrives while a burst is armed or running is ignored. After the burst ends, the pulser re-arms.
- R9: `sref_sel` = 2 routes the pulser to `sysref_out`. Values 1 and 3 hold `sysref_out` at 0.
- R10: While `sref_clr` is 1, `sysref_out` is 0.
- R11: In modes 0 and 3, SYNC does nothing. Mode 1 never starts a burst, and mode 2 never restarts a divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Distribution clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pin | input | 1 | External SYNC request, asynchronous |
| sync_inv | input | 1 | Polarity control XORed with the pin |
| sync_mode | input | 2 | 0 off, 1 divider alignment, 2 burst trigger, 3 off |
| div_hold | input | N_OUT | Per-output SYNC hold (1 = ignore SYNC) |
| sref_hold | input | 1 | SYNC hold for the SYSREF divider |
| div_val | input | N_OUT*DW | Packed divide values of the outputs |
| sref_div | input | DW | SYSREF divide value |
| burst_len | input | CW | Burst length minus one, in SYSREF periods |
| sref_sel | input | 2 | SYSREF source: 0 SYNC level, 2 pulser, others low |
| sref_clr | input | 1 | Local SYSREF clear, forces output low |
| clk_out | output | N_OUT | Divided clocks |
| sysref_out | output | 1 | SYSREF line |

## Verification
The hardest case to reach is a second SYNC edge that lands while a burst is still running. Showing that it is ignored needs a burst long enough to overlap it, so the stimulus sets a burst length of four periods and raises the pin again part-way through. It then counts exactly four pulses in the window and another four after a fresh trigger. Divider alignment against a held divider is reached by leaving the dividers with mutually prime periods, so their phases drift before the pin is raised. A cycle-level scoreboard then compares every output on every cycle.

// File: rtl/sysref_sync_ctl.sv
module sysref_sync_ctl #(
  parameter int N_OUT = 3,
  parameter int DW    = 12,
  parameter int CW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sync_pin,
  input  logic                  sync_inv,
  input  logic [1:0]            sync_mode,
  input  logic [N_OUT-1:0]      div_hold,
  input  logic                  sref_hold,
  input  logic [N_OUT*DW-1:0]   div_val,
  input  logic [DW-1:0]         sref_div,
  input  logic [CW-1:0]         burst_len,
  input  logic [1:0]            sref_sel,
  input  logic                  sref_clr,
  output logic [N_OUT-1:0]      clk_out,
  output logic                  sysref_out
);
  localparam logic [1:0] MODE_ALIGN = 2'd1;
  localparam logic [1:0] MODE_BURST = 2'd2;

  logic s1, s2, s3;
  wire  sync_i = sync_pin ^ sync_inv;
  wire  rise   = s2 & ~s3;
  wire  align  = rise && (sync_mode == MODE_ALIGN);
  wire  fire   = rise && (sync_mode == MODE_BURST);

  always_ff @(posedge clk) begin
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {sync_i, s1, s2};
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_div
    logic [DW-1:0] n, cnt, nx;
    logic          oq;
    wire           byp = (n < DW'(2));
    assign n  = div_val[i*DW +: DW];
    assign nx = (byp || (align && !div_hold[i]) || cnt >= n - 1'b1) ? '0 : cnt + 1'b1;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0;
        oq  <= 1'b0;
      end else begin
        cnt <= nx;
        oq  <= !byp && (nx < (n >> 1));
      end
    end
    assign clk_out[i] = byp ? clk : oq;
  end

  logic [DW-1:0] sc, s_nx, shi;
  wire           s_byp = (sref_div < DW'(2));
  wire           wrap  = (s_nx == '0);
  assign s_nx = (s_byp || (align && !sref_hold) || sc >= sref_div - 1'b1) ? '0 : sc + 1'b1;
  assign shi  = s_byp ? DW'(1) : (sref_div >> 1);

  logic          pend, busy, pls;
  logic [CW-1:0] rem;
  logic          pend_n, busy_n;
  logic [CW-1:0] rem_n;
  wire           trig = fire && !busy && !pend;

  always_comb begin
    pend_n = pend;
    busy_n = busy;
    rem_n  = rem;
    if (wrap) begin
      if (busy) begin
        if (rem == '0) busy_n = 1'b0;
        else           rem_n  = rem - 1'b1;
      end else if (pend || trig) begin
        busy_n = 1'b1;
        rem_n  = burst_len;
        pend_n = 1'b0;
      end
    end else if (trig) begin
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc   <= '0;
      pend <= 1'b0;
      busy <= 1'b0;
      rem  <= '0;
      pls  <= 1'b0;
    end else begin
      sc   <= s_nx;
      pend <= pend_n;
      busy <= busy_n;
      rem  <= rem_n;
      pls  <= busy_n && (s_nx < shi);
    end
  end

  assign sysref_out = sref_clr            ? 1'b0 :
                      (sref_sel == 2'd0)  ? s2   :
                      (sref_sel == 2'd2)  ? pls  : 1'b0;
endmodule

// File: rtl/sysref_sync_chk.sv
module sysref_sync_chk #(
  parameter int N_OUT = 3,
  parameter int DW    = 12,
  parameter int CW    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sync_i,
  input logic                align,
  input logic                busy,
  input logic                pls,
  input logic [CW-1:0]       rem,
  input logic [N_OUT-1:0]    div_hold,
  input logic [N_OUT*DW-1:0] div_val,
  input logic [DW-1:0]       sref_div,
  input logic [1:0]          sref_sel,
  input logic                sref_clr,
  input logic [N_OUT-1:0]    clk_out,
  input logic                sysref_out
);
  logic [1:0]    warm;
  logic          bp, pq;
  logic [CW:0]   pc;
  logic [CW-1:0] lenl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warm <= '0; bp <= 1'b0; pq <= 1'b0; pc <= '0; lenl <= '0;
    end else begin
      if (warm != 2'd3) warm <= warm + 1'b1;
      bp <= busy;
      pq <= pls;
      if (busy && !bp) begin
        pc   <= (CW+1)'(1);
        lenl <= rem;
      end else if (pls && !pq) begin
        pc <= pc + 1'b1;
      end
    end
  end

  AST_SEL0_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3 && sref_sel == 2'd0 && !sref_clr) |-> (sysref_out == $past(sync_i, 2))); // R4

  for (genvar i = 0; i < N_OUT; i++) begin : g_al
    AST_ALIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (align && !div_hold[i] && div_val[i*DW +: DW] >= DW'(2)) |=>
      (div_val[i*DW +: DW] < DW'(2) || clk_out[i])); // R5
  end

  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && sref_div >= DW'(2) && $past(sref_div) == sref_div) |-> (pc == {1'b0, lenl} + 1'b1)); // R7

  AST_SEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sref_sel[0]) |-> !sysref_out); // R9

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sref_clr |-> !sysref_out); // R10
endmodule

bind sysref_sync_ctl sysref_sync_chk #(.N_OUT(N_OUT), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .align(align), .busy(busy),
  .pls(pls), .rem(rem), .div_hold(div_hold), .div_val(div_val),
  .sref_div(sref_div), .sref_sel(sref_sel), .sref_clr(sref_clr),
  .clk_out(clk_out), .sysref_out(sysref_out)
);

// File: tb/tb_sysref_sync_ctl.sv
module tb_sysref_sync_ctl;
  localparam int N = 3, DW = 12, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sync_pin = 1'b0, sync_inv = 1'b0, sref_hold = 1'b0, sref_clr = 1'b0;
  logic [1:0] sync_mode = 2'd0, sref_sel = 2'd0;
  logic [N-1:0] div_hold = '0;
  logic [N*DW-1:0] div_val = {12'd5, 12'd3, 12'd4};
  logic [DW-1:0] sref_div = 12'd6;
  logic [CW-1:0] burst_len = 8'd1;
  logic [N-1:0] clk_out;
  logic sysref_out;

  sysref_sync_ctl #(.N_OUT(N), .DW(DW), .CW(CW)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic check(bit ok, string req, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // reference model of the requirements, feeding the scoreboard queue
  logic [N:0] expq[$];
  int m_cnt[N];
  int m_sc, m_rem;
  bit m_out[N];
  bit m_s1, m_s2, m_s3, m_pend, m_busy, m_pls;

  always @(posedge clk) begin
    logic [N:0] e;
    if (!rst_n) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_out[i] = 0; end
      m_sc = 0; m_rem = 0; {m_s1, m_s2, m_s3, m_pend, m_busy, m_pls} = '0;
    end else begin
      bit rs, al, fi, wr;
      int nx, n, sh;
      rs = m_s2 && !m_s3;
      al = rs && sync_mode == 2'd1;
      fi = rs && sync_mode == 2'd2;
      for (int i = 0; i < N; i++) begin
        n = int'(div_val[i*DW +: DW]);
        if (n < 2 || (al && !div_hold[i]) || m_cnt[i] >= n - 1) nx = 0; else nx = m_cnt[i] + 1;
        m_out[i] = (n >= 2) && (nx < n / 2);
        m_cnt[i] = nx;
      end
      n = int'(sref_div);
      if (n < 2 || (al && !sref_hold) || m_sc >= n - 1) m_sc = 0; else m_sc = m_sc + 1;
      sh = (n < 2) ? 1 : n / 2;
      wr = (m_sc == 0);
      if (wr) begin
        if (m_busy) begin
          if (m_rem == 0) m_busy = 0; else m_rem = m_rem - 1;
        end else if (m_pend || fi) begin
          m_busy = 1; m_rem = int'(burst_len); m_pend = 0;
        end
      end else if (fi && !m_busy && !m_pend) m_pend = 1;
      m_pls = m_busy && (m_sc < sh);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_pin ^ sync_inv;
    end
    for (int i = 0; i < N; i++) e[i] = (div_val[i*DW +: DW] < 2) ? 1'b1 : m_out[i];
    e[N] = sref_clr ? 1'b0 : (sref_sel == 2'd0) ? m_s2 : (sref_sel == 2'd2) ? m_pls : 1'b0;
    expq.push_back(e);
  end

  // monitor: pops and compares, also counts pulses and high cycles
  int rise_cnt = 0, sr_hi = 0;
  int hi_out[N];
  bit prev_sr = 0;
  always @(posedge clk) begin
    #1;
    if (expq.size() > 0) begin
      logic [N:0] e, got;
      e = expq.pop_front();
      got = {sysref_out, clk_out};
      check(got === e, cur_req, int'(got), int'(e));
      if (sysref_out && !prev_sr) rise_cnt++;
      if (sysref_out) sr_hi++;
      for (int i = 0; i < N; i++) if (clk_out[i]) hi_out[i]++;
      prev_sr = sysref_out;
    end
  end

  task automatic clr_counts();
    rise_cnt = 0; sr_hi = 0;
    for (int i = 0; i < N; i++) hi_out[i] = 0;
  endtask

  task automatic pulse_pin();
    @(negedge clk) sync_pin = 1'b1;
    repeat (4) @(negedge clk);
    sync_pin = 1'b0;
  endtask

  task automatic burst_window(int wait_cyc);
    clr_counts();
    pulse_pin();
    repeat (wait_cyc) @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    check(clk_out === '0, "R1", int'(clk_out), 0);
    check(sysref_out === 1'b0, "R1", int'(sysref_out), 0);
    rst_n = 1'b1;

    cur_req = "R2";
    repeat (5) @(negedge clk);
    clr_counts();
    repeat (60) @(negedge clk);
    check(hi_out[0] == 30, "R2", hi_out[0], 30);
    check(hi_out[1] == 20, "R2", hi_out[1], 20);
    check(hi_out[2] == 24, "R2", hi_out[2], 24);

    cur_req = "R4/R11";
    @(negedge clk) sync_inv = 1'b1;
    @(posedge clk); #2;
    check(sysref_out === 1'b0, "R4", int'(sysref_out), 0);
    @(posedge clk); #2;
    check(sysref_out === 1'b1, "R4", int'(sysref_out), 1);
    repeat (4) @(negedge clk);
    sync_inv = 1'b0;
    repeat (6) @(negedge clk);

    cur_req = "R5/R6";
    sync_mode = 2'd1;
    div_hold = 3'b100;
    repeat (7) @(negedge clk);
    sync_pin = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(clk_out[0] === 1'b1, "R5", int'(clk_out[0]), 1);
    check(clk_out[1] === 1'b1, "R5", int'(clk_out[1]), 1);
    @(negedge clk) sync_pin = 1'b0;
    repeat (30) @(negedge clk);

    cur_req = "R3";
    div_val[DW-1:0] = 12'd1;
    div_val[2*DW-1:DW] = 12'd0;
    @(posedge clk); #2;
    check(clk_out[0] === 1'b1, "R3", int'(clk_out[0]), 1);
    @(negedge clk); #2;
    check(clk_out[1] === 1'b0, "R3", int'(clk_out[1]), 0);
    repeat (8) @(negedge clk);
    div_val = {12'd5, 12'd3, 12'd4};
    div_hold = 3'b111;
    sref_hold = 1'b1;

    cur_req = "R7";
    sync_mode = 2'd2;
    sref_sel = 2'd2;
    burst_len = 8'd1;
    repeat (4) @(negedge clk);
    burst_window(36);
    check(rise_cnt == 2, "R7", rise_cnt, 2);
    check(sr_hi == 6, "R7", sr_hi, 6);

    cur_req = "R8";
    burst_len = 8'd3;
    clr_counts();
    pulse_pin();
    repeat (6) @(negedge clk);
    pulse_pin();
    repeat (50) @(negedge clk);
    check(rise_cnt == 4, "R8", rise_cnt, 4);
    burst_window(40);
    check(rise_cnt == 4, "R8", rise_cnt, 4);

    cur_req = "R9";
    sref_sel = 2'd1;
    burst_window(40);
    check(rise_cnt == 0, "R9", rise_cnt, 0);
    sref_sel = 2'd3;
    burst_window(40);
    check(rise_cnt == 0, "R9", rise_cnt, 0);

    cur_req = "R10";
    sref_sel = 2'd2;
    sref_clr = 1'b1;
    burst_window(40);
    check(rise_cnt == 0, "R10", rise_cnt, 0);
    sref_clr = 1'b0;

    cur_req = "R11";
    sync_mode = 2'd1;
    div_hold = 3'b000;
    burst_window(40);
    check(rise_cnt == 0, "R11", rise_cnt, 0);
    sync_mode = 2'd3;
    burst_window(40);
    check(rise_cnt == 0, "R11", rise_cnt, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule